// File: doc/BRIEF.md
# Fault-Masked LRU Instruction Cache

A read-only, set-associative instruction cache with true least-recently-used replacement. Some cache lines may hold permanently faulty storage cells, so a boot-time disable mask removes individual blocks from use. A disabled block can never hit and is never picked as a fill target. Each set's replacement ordering therefore covers only its enabled ways. Its effective depth is the associativity minus the number of disabled ways in that set, and it does not depend on which ways those are.

A fetch address arrives on a valid/ready handshake. A lookup that hits returns the instruction word one cycle after acceptance. A lookup that misses issues one full-line read to memory. When the line returns, the requested word is forwarded and the line is written into the least-recently-used enabled way. If a set has no enabled way, every access to it misses and the word is forwarded without being stored.

A build option makes way 0 of every set fault-resilient, so its disable bit is ignored. With that option a set always keeps at least one usable line, like a direct-mapped cache. Replacement ordering and valid bits are taken to be fault-free. Loading a new mask clears every line and restarts the ordering.

Top module: `fault_masked_icache`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: A hit is answered with `rsp_valid`=1 and `rsp_hit`=1 in the cycle right after the request is accepted, and `rsp_data` carries the cached word.
- R3: A miss raises `mem_req_valid` for exactly one cycle, and `req_ready` stays 0 until the response. The response carries `rsp_hit`=0 and comes one cycle after `mem_rsp_valid`.
- R4: On a miss, the victim is the least-recently-used enabled way of the set. Both a hit and a fill make the accessed way the most recently used.
- R5: Bit s*WAYS+w of `mask_bits` disables way w of set s. A disabled way never hits and is never filled, so a set with d disabled ways holds at most WAYS-d lines.
- R6: With RELIABLE_WAY0=1, the disable bit of way 0 has no effect, so a set whose mask bits are all 1 still keeps one line.
- R7: With RELIABLE_WAY0=0 and every way of a set disabled, every access to that set misses and still returns the correct word from memory.
- R8: A `mask_load` pulse invalidates every line and restores the initial ordering, in which lower way numbers count as more recently used.
- R9: `mem_req_addr` is the fetch address with the line-offset bits dropped. The returned word is `mem_rsp_line[WORD_W*i +: WORD_W]`, where i is the word index held in the address offset bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_load | input | 1 | Load the disable mask, clear all lines |
| mask_bits | input | SETS*WAYS | Disable bit per block, index s*WAYS+w |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Cache can accept a fetch |
| req_addr | input | ADDR_W | Fetch byte address |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | 1 when the response came from the cache |
| rsp_data | output | WORD_W | Fetched instruction word |
| mem_req_valid | output | 1 | Line read request pulse |
| mem_req_addr | output | ADDR_W-OFF_W | Line address to read |
| mem_rsp_valid | input | 1 | Line data returned |
| mem_rsp_line | input | LINE_BYTES*8 | Returned line |

## Verification
The bench goes after victim choice in sets with disabled ways. A design that counted disabled ways in its ordering, or filled them, would keep one line too many or evict the wrong line, and a later fetch would hit where a miss is due. A fully masked set is checked with and without the resilient way. A cache that dropped the way-0 override would miss on every repeat. A cache that stored into a disabled block would hit where a miss is due. Mask reloads are checked for leftover lines, which would show up as stale hits. Word selection inside the line is checked, since an offset decoding error returns the wrong word on a correct hit.

// File: rtl/fault_masked_icache.sv
module fault_masked_icache #(
  parameter int ADDR_W        = 32,
  parameter int WORD_W        = 32,
  parameter int SETS          = 16,
  parameter int WAYS          = 4,
  parameter int LINE_BYTES    = 16,
  parameter bit RELIABLE_WAY0 = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mask_load,
  input  logic [SETS*WAYS-1:0]         mask_bits,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [WORD_W-1:0]            rsp_data,
  output logic                         mem_req_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] mem_req_addr,
  input  logic                         mem_rsp_valid,
  input  logic [LINE_BYTES*8-1:0]      mem_rsp_line
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int BPW    = WORD_W / 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int AGE_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  typedef enum logic {S_IDLE, S_WAIT} state_t;
  state_t state;

  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [LINE_W-1:0] data_q  [SETS][WAYS];
  logic [AGE_W-1:0]  age_q   [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dis_q   [SETS];
  logic [ADDR_W-1:0] addr_q;

  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic [WAYS-1:0]   en_vec, hit_vec;
  logic [AGE_W-1:0]  hit_way, vic_way, acc_way;
  logic              hit, any_en, fill;

  function automatic logic [WORD_W-1:0] pick(input logic [LINE_W-1:0] line,
                                             input logic [ADDR_W-1:0] a);
    logic [LINE_W-1:0] sh;
    sh = line >> (WORD_W * (int'(a[OFF_W-1:0]) / BPW));
    return sh[WORD_W-1:0];
  endfunction

  assign lk_addr      = (state == S_WAIT) ? addr_q : req_addr;
  assign lk_idx       = lk_addr[OFF_W +: IDX_W];
  assign lk_tag       = lk_addr[ADDR_W-1 -: TAG_W];
  assign en_vec       = ~dis_q[lk_idx];
  assign any_en       = |en_vec;
  assign hit          = |hit_vec;
  assign acc_way      = hit ? hit_way : vic_way;
  assign req_ready    = (state == S_IDLE) && !mask_load;
  assign mem_req_addr = addr_q[ADDR_W-1:OFF_W];
  assign fill         = !mask_load && (state == S_WAIT) && mem_rsp_valid && any_en;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_q[lk_idx][w] && en_vec[w] && (tag_q[lk_idx][w] == lk_tag);
      if (hit_vec[w]) hit_way = AGE_W'(w);
    end
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    vic_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (en_vec[w] && (!found || age_q[lk_idx][w] > age_q[lk_idx][vic_way])) begin
        found   = 1'b1;
        vic_way = AGE_W'(w);
      end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q[lk_idx][vic_way]  <= lk_tag;
      data_q[lk_idx][vic_way] <= mem_rsp_line;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mask_load) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= AGE_W'(w);
          dis_q[s][w] <= rst_n && mask_bits[s*WAYS+w] && !(RELIABLE_WAY0 && w == 0);
        end
      end
      state         <= S_IDLE;
      rsp_valid     <= 1'b0;
      mem_req_valid <= 1'b0;
      if (!rst_n) begin
        rsp_hit  <= 1'b0;
        rsp_data <= '0;
        addr_q   <= '0;
      end
    end else begin
      rsp_valid     <= 1'b0;
      mem_req_valid <= 1'b0;
      if ((state == S_IDLE && req_valid && hit) || fill) begin
        for (int w = 0; w < WAYS; w++)
          if (en_vec[w] && age_q[lk_idx][w] < age_q[lk_idx][acc_way])
            age_q[lk_idx][w] <= age_q[lk_idx][w] + AGE_W'(1);
        age_q[lk_idx][acc_way] <= '0;
      end
      case (state)
        S_IDLE: if (req_valid) begin
          if (hit) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b1;
            rsp_data  <= pick(data_q[lk_idx][hit_way], req_addr);
          end else begin
            addr_q        <= req_addr;
            mem_req_valid <= 1'b1;
            state         <= S_WAIT;
          end
        end
        S_WAIT: if (mem_rsp_valid) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b0;
          rsp_data  <= pick(mem_rsp_line, addr_q);
          if (any_en) valid_q[lk_idx][vic_way] <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fault_masked_icache_chk.sv
module fault_masked_icache_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic mem_req_valid,
  input logic mem_rsp_valid,
  input logic mask_load
);
  assert_hit_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $past(req_valid && req_ready));

  assert_busy_during_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_single_line_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  assert_miss_after_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> $past(mem_rsp_valid));

  assert_no_hit_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_load) |-> !(rsp_valid && rsp_hit));
endmodule

bind fault_masked_icache fault_masked_icache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .mem_req_valid(mem_req_valid),
  .mem_rsp_valid(mem_rsp_valid), .mask_load(mask_load)
);

// File: tb/fault_masked_icache_tb.sv
module fault_masked_icache_tb;
  localparam int MEM_LAT = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        mask_load     [2];
  logic [63:0] mask_bits     [2];
  logic        req_valid     [2];
  logic        req_ready     [2];
  logic [31:0] req_addr      [2];
  logic        rsp_valid     [2];
  logic        rsp_hit       [2];
  logic [31:0] rsp_data      [2];
  logic        mem_req_valid [2];
  logic [27:0] mem_req_addr  [2];
  logic        mem_rsp_valid [2];
  logic [127:0] mem_rsp_line [2];

  for (genvar d = 0; d < 2; d++) begin : g_dut
    fault_masked_icache #(.RELIABLE_WAY0(d == 0)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .mask_load(mask_load[d]), .mask_bits(mask_bits[d]),
      .req_valid(req_valid[d]), .req_ready(req_ready[d]), .req_addr(req_addr[d]),
      .rsp_valid(rsp_valid[d]), .rsp_hit(rsp_hit[d]), .rsp_data(rsp_data[d]),
      .mem_req_valid(mem_req_valid[d]), .mem_req_addr(mem_req_addr[d]),
      .mem_rsp_valid(mem_rsp_valid[d]), .mem_rsp_line(mem_rsp_line[d]));
  end

  int checks = 0;
  int failures = 0;

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3A5_0000;
  endfunction

  function automatic logic [127:0] line_of(input logic [27:0] la);
    logic [127:0] l;
    for (int i = 0; i < 4; i++) l[32*i +: 32] = word_of({la, 4'(i * 4)});
    return l;
  endfunction

  initial begin
    for (int d = 0; d < 2; d++) begin
      mem_rsp_valid[d] = 1'b0;
      mem_rsp_line[d]  = '0;
    end
    forever begin
      @(posedge clk);
      for (int d = 0; d < 2; d++)
        if (mem_req_valid[d]) begin
          logic [27:0] la;
          la = mem_req_addr[d];
          repeat (MEM_LAT) @(negedge clk);
          mem_rsp_valid[d] = 1'b1;
          mem_rsp_line[d]  = line_of(la);
          @(negedge clk);
          mem_rsp_valid[d] = 1'b0;
        end
    end
  end

  logic [23:0] tag_m [2][16][4];
  bit          val_m [2][16][4];
  int          ord_m [2][16][4];
  int          cnt_m [2][16];

  task automatic model_load(input int d, input logic [63:0] m);
    for (int s = 0; s < 16; s++) begin
      cnt_m[d][s] = 0;
      for (int w = 0; w < 4; w++) begin
        val_m[d][s][w] = 1'b0;
        if (!m[s*4+w] || (d == 0 && w == 0)) begin
          ord_m[d][s][cnt_m[d][s]] = w;
          cnt_m[d][s]++;
        end
      end
    end
  endtask

  task automatic model_access(input int d, input logic [31:0] a, output bit h);
    int s, p, w;
    s = int'(a[7:4]);
    p = -1;
    h = 1'b0;
    for (int i = 0; i < cnt_m[d][s]; i++)
      if (val_m[d][s][ord_m[d][s][i]] && tag_m[d][s][ord_m[d][s][i]] == a[31:8] && p < 0) p = i;
    if (p >= 0) h = 1'b1;
    else if (cnt_m[d][s] > 0) begin
      p = cnt_m[d][s] - 1;
      tag_m[d][s][ord_m[d][s][p]] = a[31:8];
      val_m[d][s][ord_m[d][s][p]] = 1'b1;
    end
    if (p >= 0) begin
      w = ord_m[d][s][p];
      for (int i = p; i > 0; i--) ord_m[d][s][i] = ord_m[d][s][i-1];
      ord_m[d][s][0] = w;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load_mask(input int d, input logic [63:0] m);
    @(negedge clk);
    mask_load[d] = 1'b1;
    mask_bits[d] = m;
    @(negedge clk);
    mask_load[d] = 1'b0;
    model_load(d, m);
  endtask

  task automatic fetch(input int d, input logic [31:0] a, input string req);
    bit eh;
    int n;
    model_access(d, a, eh);
    @(negedge clk);
    req_valid[d] = 1'b1;
    req_addr[d]  = a;
    check(req_ready[d] == 1'b1, req, "ready before accept", 64'(req_ready[d]), 64'd1);
    @(negedge clk);
    req_valid[d] = 1'b0;
    n = 1;
    while (!rsp_valid[d] && n < 1000) begin
      if (!eh && n == 2)
        check(req_ready[d] == 1'b0, "R3", "ready low during miss", 64'(req_ready[d]), 64'd0);
      @(negedge clk);
      n++;
    end
    check(rsp_hit[d] == eh, req, "hit flag", 64'(rsp_hit[d]), 64'(eh));
    check(rsp_data[d] == word_of(a), eh ? req : "R9", "data", 64'(rsp_data[d]), 64'(word_of(a)));
    check(n == (eh ? 1 : MEM_LAT + 2), eh ? "R2" : "R3", "latency", 64'(n), 64'(eh ? 1 : MEM_LAT + 2));
  endtask

  task automatic t_reset();
    for (int d = 0; d < 2; d++) begin
      check(req_ready[d] == 1'b1, "R1", "ready after reset", 64'(req_ready[d]), 64'd1);
      check(rsp_valid[d] == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid[d]), 64'd0);
      check(mem_req_valid[d] == 1'b0, "R1", "mem_req after reset", 64'(mem_req_valid[d]), 64'd0);
    end
  endtask

  task automatic t_basic();
    load_mask(0, 64'd0);
    fetch(0, 32'h0000_1000, "R3");
    fetch(0, 32'h0000_1004, "R2");
    fetch(0, 32'h0000_100C, "R9");
    fetch(0, 32'h0000_2008, "R3");
    fetch(0, 32'h0000_1008, "R2");
  endtask

  task automatic t_lru();
    for (int k = 0; k < 4; k++) fetch(0, 32'h0001_0020 + 32'(k << 8), "R4");
    fetch(0, 32'h0001_0020, "R4");
    fetch(0, 32'h0001_0420, "R4");
    fetch(0, 32'h0001_0120, "R4");
    fetch(0, 32'h0001_0020, "R4");
    fetch(0, 32'h0001_0320, "R4");
  endtask

  task automatic t_disabled();
    load_mask(1, 64'h00A0_0000);
    fetch(1, 32'h0002_0050, "R5");
    fetch(1, 32'h0002_0150, "R5");
    fetch(1, 32'h0002_0050, "R5");
    fetch(1, 32'h0002_0154, "R5");
    fetch(1, 32'h0002_0250, "R5");
    fetch(1, 32'h0002_0050, "R5");
    fetch(1, 32'h0002_0250, "R5");
  endtask

  task automatic t_reliable();
    load_mask(0, 64'h0F00_0000);
    fetch(0, 32'h0003_0060, "R6");
    fetch(0, 32'h0003_0064, "R6");
    fetch(0, 32'h0003_0160, "R6");
    fetch(0, 32'h0003_0060, "R6");
  endtask

  task automatic t_dead();
    load_mask(1, 64'h0F00_0000);
    fetch(1, 32'h0003_0060, "R7");
    fetch(1, 32'h0003_0064, "R7");
    fetch(1, 32'h0003_0068, "R7");
    fetch(1, 32'h0003_0070, "R7");
  endtask

  task automatic t_reload();
    fetch(0, 32'h0004_0010, "R8");
    fetch(0, 32'h0004_0010, "R8");
    load_mask(0, 64'd0);
    fetch(0, 32'h0004_0010, "R8");
    fetch(0, 32'h0004_0014, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      mask_load[d] = 1'b0;
      mask_bits[d] = '0;
      req_valid[d] = 1'b0;
      req_addr[d]  = '0;
      model_load(d, 64'd0);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lru();
    t_disabled();
    t_reliable();
    t_dead();
    t_reload();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule